// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the sampling enable for one direction of a serial port from a reference clock. The reference clock first goes through a prescaler that divides by 1 or by 4. A 16-bit integer divisor then sets the number of prescaled cycles in each oversample period. A 4-bit fraction, counted in sixteenths, lengthens some of those periods by one prescaled cycle. This makes the average period the integer divisor plus the fraction divided by 16.

The block produces two outputs. The first is a one-cycle oversample tick. The second is a bit-period tick that marks every 16th, 8th or 4th oversample tick, as chosen by a 2-bit rate select. Both are single-cycle enables in the reference clock domain, not derived clocks. A transmitter and a receiver each use their own instance, so the two directions can run at different rates. An integer divisor of zero stops the generator. Any change to the configuration restarts the counters, so a new rate starts from a clean phase.

Top module: `frac_baud_gen`

## Requirements
- R1: While rst_ni is low, os_tick_o and bit_tick_o are 0.
- R2: When the integer divisor {div_hi_i, div_lo_i} is zero, the generator is stopped and neither tick is ever asserted.
- R3: With prescaler 1 and fraction 0, os_tick_o is high for exactly one cycle in every D reference cycles, where D = {div_hi_i, div_lo_i}.
- R4: When pre_sel_i is 1, the prescaler divides by 4, so every oversample period is four times as many reference cycles. Two oversample ticks are then never in adjacent cycles. When pre_sel_i is 0, the prescaler divides by 1.
- R5: A 4-bit accumulator starts at 0 after a restart. At each oversample tick it adds div_frac_i. When that addition carries out of 4 bits, the next oversample period is D+1 prescaled cycles instead of D. Over any 16 consecutive periods, exactly div_frac_i periods are lengthened.
- R6: os_sel_i sets the oversampling ratio N: 2'b00 gives 16, 2'b01 gives 8, 2'b10 gives 4, and 2'b11 gives 16. bit_tick_o is asserted together with the N-th, 2N-th, ... oversample tick counted from a restart.
- R7: Any change of div_hi_i, div_lo_i, div_frac_i, os_sel_i or pre_sel_i restarts the generator. No tick is produced in the cycle where the change is seen. The prescaler, the period counter, the accumulator and the ratio counter are all zero in the following cycle, so the first period after the change is a full, unlengthened period.
- R8: bit_tick_o is only ever asserted in a cycle where os_tick_o is also asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_hi_i | input | 8 | Integer divisor, upper byte |
| div_lo_i | input | 8 | Integer divisor, lower byte |
| div_frac_i | input | 4 | Fractional divisor in sixteenths |
| os_sel_i | input | 2 | Oversampling ratio select |
| pre_sel_i | input | 1 | Prescaler select: 0 divides by 1, 1 divides by 4 |
| os_tick_o | output | 1 | One-cycle oversample enable |
| bit_tick_o | output | 1 | One-cycle bit-period enable |

## Verification
Each error in the internal state shows at the ports within one oversample period. A wrong accumulator value or a lost carry moves a single oversample tick by one prescaled cycle. A stale period count or prescaler phase after a configuration change moves the first tick after the restart. A wrong ratio count moves bit_tick_o to a different oversample tick within one bit period. For these reasons the bench checks the exact cycle of every tick, and it checks every cycle in between for a tick that should not be there.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int unsigned INT_W  = 16;
  localparam int unsigned FRAC_W = 4;
  localparam int unsigned PRE_DIV = 4;
  localparam int unsigned OS_MAX = 16;

  typedef enum logic [1:0] {
    OS_16X  = 2'b00,
    OS_8X   = 2'b01,
    OS_4X   = 2'b10,
    OS_16XB = 2'b11
  } os_sel_e;
endpackage

// File: rtl/fbg_prescale.sv
module fbg_prescale #(
  parameter int unsigned DIV = fbg_pkg::PRE_DIV
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic sel_i,
  output logic en_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  assign en_o = sel_i ? (cnt_q == LAST) : 1'b1;
endmodule

// File: rtl/fbg_frac_div.sv
module fbg_frac_div #(
  parameter int unsigned INT_W  = fbg_pkg::INT_W,
  parameter int unsigned FRAC_W = fbg_pkg::FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [INT_W-1:0]  div_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              tick_o
);
  logic [INT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic              ext_q;
  logic              run;
  logic              hit;
  logic [INT_W:0]    cnt_p1;
  logic [INT_W:0]    lim;
  logic [FRAC_W:0]   sum;

  assign run    = |div_i;
  assign cnt_p1 = {1'b0, cnt_q} + {{INT_W{1'b0}}, 1'b1};
  // period is div_i plus one extra when the previous accumulation carried
  assign lim    = {1'b0, div_i} + {{INT_W{1'b0}}, ext_q};
  assign hit    = (cnt_p1 == lim);
  assign sum    = {1'b0, acc_q} + {1'b0, frac_i};
  assign tick_o = run & en_i & hit & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
      ext_q <= 1'b0;
    end else if (clr_i || !run) begin
      cnt_q <= '0;
      acc_q <= '0;
      ext_q <= 1'b0;
    end else if (en_i) begin
      if (hit) begin
        cnt_q <= '0;
        acc_q <= sum[FRAC_W-1:0];
        ext_q <= sum[FRAC_W];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fbg_bit_cnt.sv
module fbg_bit_cnt #(
  parameter int unsigned OS_MAX = fbg_pkg::OS_MAX
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       os_tick_i,
  input  logic [1:0] sel_i,
  output logic       bit_tick_o
);
  localparam int unsigned CW = $clog2(OS_MAX);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic          hit;

  always_comb begin
    unique case (fbg_pkg::os_sel_e'(sel_i))
      fbg_pkg::OS_8X: last = CW'(OS_MAX / 2 - 1);
      fbg_pkg::OS_4X: last = CW'(OS_MAX / 4 - 1);
      default:        last = CW'(OS_MAX - 1);
    endcase
  end

  assign hit        = (cnt_q == last);
  assign bit_tick_o = os_tick_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (os_tick_i) cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int unsigned INT_W   = fbg_pkg::INT_W,
  parameter int unsigned FRAC_W  = fbg_pkg::FRAC_W,
  parameter int unsigned PRE_DIV = fbg_pkg::PRE_DIV,
  parameter int unsigned OS_MAX  = fbg_pkg::OS_MAX
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [INT_W/2-1:0]  div_hi_i,
  input  logic [INT_W/2-1:0]  div_lo_i,
  input  logic [FRAC_W-1:0]   div_frac_i,
  input  logic [1:0]          os_sel_i,
  input  logic                pre_sel_i,
  output logic                os_tick_o,
  output logic                bit_tick_o
);
  localparam int unsigned CFG_W = INT_W + FRAC_W + 3;

  logic [INT_W-1:0] div;
  logic [CFG_W-1:0] cfg, cfg_q;
  logic             cfg_chg;
  logic             pre_en;

  assign div     = {div_hi_i, div_lo_i};
  assign cfg     = {div, div_frac_i, os_sel_i, pre_sel_i};
  assign cfg_chg = (cfg != cfg_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg;
  end

  fbg_prescale #(.DIV(PRE_DIV)) i_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cfg_chg),
    .sel_i (pre_sel_i),
    .en_o  (pre_en)
  );

  fbg_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cfg_chg),
    .en_i  (pre_en),
    .div_i (div),
    .frac_i(div_frac_i),
    .tick_o(os_tick_o)
  );

  fbg_bit_cnt #(.OS_MAX(OS_MAX)) i_bit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cfg_chg),
    .os_tick_i (os_tick_o),
    .sel_i     (os_sel_i),
    .bit_tick_o(bit_tick_o)
  );
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] div_hi_i,
  input logic [7:0] div_lo_i,
  input logic [3:0] div_frac_i,
  input logic [1:0] os_sel_i,
  input logic       pre_sel_i,
  input logic       os_tick_o,
  input logic       bit_tick_o
);
  always_comb begin
    if (!rst_ni) AST_RESET_QUIET: assert (!os_tick_o && !bit_tick_o); // R1
  end

  AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({div_hi_i, div_lo_i} == 16'd0) |-> !os_tick_o); // R2

  AST_PRE4_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (os_tick_o && pre_sel_i) |=> !os_tick_o); // R4

  AST_RESTART_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({div_hi_i, div_lo_i, div_frac_i, os_sel_i, pre_sel_i} !=
     $past({div_hi_i, div_lo_i, div_frac_i, os_sel_i, pre_sel_i})) |-> !os_tick_o); // R7

  AST_BIT_WITH_OS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> os_tick_o); // R8
endmodule

bind frac_baud_gen frac_baud_gen_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .div_hi_i  (div_hi_i),
  .div_lo_i  (div_lo_i),
  .div_frac_i(div_frac_i),
  .os_sel_i  (os_sel_i),
  .pre_sel_i (pre_sel_i),
  .os_tick_o (os_tick_o),
  .bit_tick_o(bit_tick_o)
);

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_hi = '0, div_lo = '0;
  logic [3:0] frac = '0;
  logic [1:0] os_sel = '0;
  logic       pre_sel = 1'b0;
  logic       os_tick, bit_tick;
  int         checks = 0, errors = 0;

  always #4ns clk = ~clk;

  frac_baud_gen i_frac_baud_gen (
    .clk_i(clk), .rst_ni(rst_n), .div_hi_i(div_hi), .div_lo_i(div_lo),
    .div_frac_i(frac), .os_sel_i(os_sel), .pre_sel_i(pre_sel),
    .os_tick_o(os_tick), .bit_tick_o(bit_tick));

  function automatic int ratio(input logic [1:0] s);
    return (s == 2'b01) ? 8 : (s == 2'b10) ? 4 : 16;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Apply a configuration at a negedge, then check every cycle of nper periods.
  task automatic run_cfg(input int d, input int f, input int os, input int pre, input int nper);
    int acc = 0, ext = 0, n_ratio, mult, bad_os, bad_bit, first_len;
    div_hi = d[15:8]; div_lo = d[7:0]; frac = f[3:0];
    os_sel = os[1:0]; pre_sel = pre[0];
    n_ratio = ratio(os[1:0]);
    mult = pre ? 4 : 1;
    for (int p = 1; p <= nper; p++) begin
      int len = (d + ext) * mult;
      bad_os = 0; bad_bit = 0;
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        if (os_tick !== (i == len - 1)) bad_os++;
        if (bit_tick !== ((i == len - 1) && (p % n_ratio == 0))) bad_bit++;
      end
      if (p == 1) first_len = len;
      // R3 R4 R5 R7: oversample tick lands exactly at end of each computed period
      check(bad_os == 0, (f != 0) ? "R5" : (pre != 0) ? "R4" : (p == 1) ? "R7" : "R3",
            bad_os, 0);
      // R6 R8: bit tick on every N-th oversample tick only
      check(bad_bit == 0, "R6", bad_bit, 0);
      ext = ((acc + f) >= 16) ? 1 : 0;
      acc = (acc + f) % 16;
    end
  endtask

  initial begin
    int d, f, os, pre, pd, pf;
    void'($urandom(32'd1234));
    repeat (3) begin
      @(negedge clk);
      check(os_tick == 1'b0 && bit_tick == 1'b0, "R1", {os_tick, bit_tick}, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R2: zero divisor stays stopped, whatever the fraction and selects are
    frac = 4'd9; pre_sel = 1'b0; os_sel = 2'b10;
    begin
      int hits = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (os_tick || bit_tick) hits++;
      end
      check(hits == 0, "R2", hits, 0);
    end
    // directed corners
    run_cfg(1, 0, 2'b10, 0, 12);   // R3 smallest divisor, tick every cycle
    run_cfg(5, 0, 2'b00, 0, 33);   // R3 R6 16x
    run_cfg(3, 0, 2'b01, 1, 17);   // R4 R6 8x
    run_cfg(1, 15, 2'b10, 0, 20);  // R5 max fraction on smallest divisor
    run_cfg(2, 8, 2'b11, 1, 33);   // R5 R6 code 11 acts as 16x
    run_cfg(300, 3, 2'b10, 0, 5);  // R3 R5 wide divisor
    run_cfg(300, 3, 2'b10, 1, 2);  // R7 prescaler-only change restarts
    // R7: change mid-period, then restart must hold
    div_lo = 8'd7; div_hi = 8'd0;
    repeat (5) @(negedge clk);
    pd = 7; pf = 0;
    for (int t = 0; t < 30; t++) begin
      d = 1 + int'($urandom_range(11));
      f = int'($urandom_range(15));
      os = int'($urandom_range(3));
      pre = int'($urandom_range(1));
      if (d == pd && f == pf) f = (f + 1) % 16;
      run_cfg(d, f, os, pre, 2 * ratio(os[1:0]) + 1);
      pd = d; pf = f;
      // partial period before the next change exercises mid-period restart
      repeat (int'($urandom_range(3))) @(negedge clk);
    end
    // R2: divisor back to zero stops ticks
    div_hi = 0; div_lo = 0;
    @(negedge clk);
    begin
      int hits = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (os_tick || bit_tick) hits++;
      end
      check(hits == 0, "R2", hits, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule